// File: doc/BRIEF.md
# Rename Table with Lifetime Tracking

This block is the register alias table of an out-of-order core in which reorder-buffer slots double as physical registers. Every architectural register points either at a reorder-buffer slot, when the newest value is still in flight, or at the architectural register file, when it has been retired. One instruction is renamed per cycle. Its source operands are looked up against the mapping as it stood before that instruction, and its destination is then steered to the reorder-buffer slot the instruction was given.

Alongside the mapping, the table tracks whether each in-flight result has already been superseded. When a new instruction overwrites a destination whose value still lives in slot k, the table flags slot k as renamed. It also hands k to the new instruction, to be stored in that entry's early-retire field, so that at commit the earlier value can be dropped from a small side register file. Writeback logic probes the flag one cycle before slot k writes back. A set flag marks the result as short-lived. A per-slot array keeps the tag of the latest conditional branch ahead of each instruction. Commit moves a mapping back to the register file when the committing slot is still the newest producer. A flush input sends every mapping back to the register file.

Top module: `lifetime_rename_table`

## Requirements
- R1: After reset every architectural register reads as held in the register file (`src_*_in_arf`=1), and every slot's short-lived flag (`wb_short_lived`) and branch tag (`probe_btag`) read 0.
- R2: A rename with a destination (`ren_valid`=1, `ren_has_dst`=1, `flush_to_arf`=0) maps that destination to `ren_slot` with `in_arf`=0 from the next cycle on.
- R3: If the renamed destination currently maps to slot k with `in_arf`=0, then `prev_valid`=1 and `prev_slot`=k in the same cycle, and slot k's short-lived flag reads 1 from the next cycle on.
- R4: If the renamed destination currently maps to the register file, or `ren_has_dst`=0, then `prev_valid`=0 and no short-lived flag is set.
- R5: Source lookups show the mapping from before the current cycle's destination update, including a source equal to the destination being renamed.
- R6: Every rename (`ren_valid`=1, no flush) writes `ren_btag` into the branch-tag entry of `ren_slot`. `probe_btag` returns the entry of `probe_slot` combinationally.
- R7: Every rename clears the short-lived flag of `ren_slot`, whether or not the instruction has a destination. When the slot being cleared equals the slot being flagged in the same cycle, the clear wins.
- R8: `wb_short_lived` equals the stored flag of `probe_slot` in the same cycle, with no register in the read path.
- R9: A commit (`commit_valid`=1) whose `commit_slot` equals the current slot mapping of `commit_dst` (with `in_arf`=0) moves that mapping to the register file from the next cycle. Any other commit changes nothing. A rename of the same destination in the same cycle takes precedence.
- R10: `flush_to_arf`=1 maps every register to the register file from the next cycle. Rename and commit inputs in that cycle have no effect on the mapping, the short-lived flags or the branch tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is renamed this cycle |
| ren_has_dst | input | 1 | The instruction writes a destination register |
| ren_dst | input | AREG_W | Destination architectural register |
| ren_src_a | input | AREG_W | First source architectural register |
| ren_src_b | input | AREG_W | Second source architectural register |
| ren_slot | input | SLOT_W | Reorder-buffer slot allocated to the instruction |
| ren_btag | input | TAG_W | Tag of the latest conditional branch ahead of it |
| src_a_slot | output | SLOT_W | Slot holding source A (valid when src_a_in_arf=0) |
| src_a_in_arf | output | 1 | Source A is in the register file |
| src_b_slot | output | SLOT_W | Slot holding source B (valid when src_b_in_arf=0) |
| src_b_in_arf | output | 1 | Source B is in the register file |
| prev_valid | output | 1 | The destination had an in-flight producer |
| prev_slot | output | SLOT_W | Slot of that producer, for the early-retire field |
| commit_valid | input | 1 | A destination-writing instruction commits |
| commit_dst | input | AREG_W | Destination of the committing instruction |
| commit_slot | input | SLOT_W | Slot of the committing instruction |
| flush_to_arf | input | 1 | Send every mapping to the register file |
| probe_slot | input | SLOT_W | Slot probed ahead of writeback |
| wb_short_lived | output | 1 | Probed slot's result is already superseded |
| probe_btag | output | TAG_W | Branch tag stored for the probed slot |

## Verification
The hardest case to reach is the collision in which the slot being reallocated is the same slot that the destination's previous producer occupies. The flag must then end up cleared. The bench builds this by renaming a register into slot 9 and then renaming it again into slot 9. The same-cycle commit-and-rename race on one destination is forced the same way, and a flush is issued together with a rename and a commit. A long run of pseudo-random renames, commits and probes is then compared against a reference model written from the requirements.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
    // Where the newest value of an architectural register lives.
    typedef enum logic {
        LOC_ROB = 1'b0,
        LOC_ARF = 1'b1
    } loc_e;
endpackage

// File: rtl/lrt_map_table.sv
module lrt_map_table #(
    parameter int NUM_AREGS = 8,
    parameter int ROB_DEPTH = 16,
    localparam int AREG_W   = $clog2(NUM_AREGS),
    localparam int SLOT_W   = $clog2(ROB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AREG_W-1:0] src_a,
    input  logic [AREG_W-1:0] src_b,
    output logic [SLOT_W-1:0] a_slot,
    output logic              a_in_arf,
    output logic [SLOT_W-1:0] b_slot,
    output logic              b_in_arf,
    input  logic [AREG_W-1:0] dst,
    output logic [SLOT_W-1:0] dst_slot,
    output logic              dst_in_arf,
    input  logic              upd_en,
    input  logic [SLOT_W-1:0] upd_slot,
    input  logic              cmt_en,
    input  logic [AREG_W-1:0] cmt_dst,
    input  logic [SLOT_W-1:0] cmt_slot,
    input  logic              flush
);
    import lrt_pkg::*;

    typedef struct packed {
        logic [NUM_AREGS-1:0]             loc;
        logic [NUM_AREGS-1:0][SLOT_W-1:0] slot;
    } map_t;

    map_t map_d, map_q;
    logic cmt_hit;

    // Lookups read the registered state only: pre-update view.
    assign a_slot     = map_q.slot[src_a];
    assign a_in_arf   = map_q.loc[src_a];
    assign b_slot     = map_q.slot[src_b];
    assign b_in_arf   = map_q.loc[src_b];
    assign dst_slot   = map_q.slot[dst];
    assign dst_in_arf = map_q.loc[dst];

    always_comb begin
        map_d   = map_q;
        cmt_hit = cmt_en && (map_q.loc[cmt_dst] == LOC_ROB)
                  && (map_q.slot[cmt_dst] == cmt_slot)
                  && !(upd_en && (dst == cmt_dst));
        if (flush) begin
            for (int i = 0; i < NUM_AREGS; i++) begin
                map_d.loc[i]  = LOC_ARF;
                map_d.slot[i] = '0;
            end
        end else begin
            if (cmt_hit) begin
                map_d.loc[cmt_dst] = LOC_ARF;
            end
            if (upd_en) begin
                map_d.loc[dst]  = LOC_ROB;
                map_d.slot[dst] = upd_slot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_AREGS; i++) begin
                map_q.loc[i]  <= LOC_ARF;
                map_q.slot[i] <= '0;
            end
        end else begin
            map_q <= map_d;
        end
    end

    AST_DST_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !flush) |=> (map_q.loc[$past(dst)] == LOC_ROB)
                               && (map_q.slot[$past(dst)] == $past(upd_slot))); // R2

    AST_FLUSH_ALL_ARF: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ($countones(map_q.loc) == NUM_AREGS)); // R10

    AST_COMMIT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_en && !flush && !upd_en && !map_q.loc[cmt_dst]
         && (map_q.slot[cmt_dst] == cmt_slot))
        |=> map_q.loc[$past(cmt_dst)]); // R9

endmodule

// File: rtl/lrt_renamed_vec.sv
module lrt_renamed_vec #(
    parameter int ROB_DEPTH = 16,
    localparam int SLOT_W   = $clog2(ROB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [SLOT_W-1:0] set_idx,
    input  logic              clr_en,
    input  logic [SLOT_W-1:0] clr_idx,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic              rd_bit
);
    typedef struct packed {
        logic [ROB_DEPTH-1:0] bits;
    } flags_t;

    flags_t flags_d, flags_q;

    assign rd_bit = flags_q.bits[rd_idx];

    always_comb begin
        flags_d = flags_q;
        if (set_en) begin
            flags_d.bits[set_idx] = 1'b1;
        end
        // Reallocation is applied last so it wins a collision.
        if (clr_en) begin
            flags_d.bits[clr_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    AST_PRIOR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !(clr_en && (clr_idx == set_idx)))
        |=> flags_q.bits[$past(set_idx)]); // R3

    AST_REALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !flags_q.bits[$past(clr_idx)]); // R7

endmodule

// File: rtl/lrt_tag_array.sv
module lrt_tag_array #(
    parameter int ROB_DEPTH = 16,
    parameter int TAG_W     = 4,
    localparam int SLOT_W   = $clog2(ROB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [TAG_W-1:0]  rd_tag
);
    typedef struct packed {
        logic [ROB_DEPTH-1:0][TAG_W-1:0] tag;
    } tags_t;

    tags_t tags_d, tags_q;

    assign rd_tag = tags_q.tag[rd_idx];

    always_comb begin
        tags_d = tags_q;
        if (wr_en) begin
            tags_d.tag[wr_idx] = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags_q <= '0;
        end else begin
            tags_q <= tags_d;
        end
    end

    AST_TAG_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tags_q.tag[$past(wr_idx)] == $past(wr_tag))); // R6

endmodule

// File: rtl/lifetime_rename_table.sv
module lifetime_rename_table #(
    parameter int NUM_AREGS = 8,
    parameter int ROB_DEPTH = 16,
    parameter int TAG_W     = 4,
    localparam int AREG_W   = $clog2(NUM_AREGS),
    localparam int SLOT_W   = $clog2(ROB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic              ren_has_dst,
    input  logic [AREG_W-1:0] ren_dst,
    input  logic [AREG_W-1:0] ren_src_a,
    input  logic [AREG_W-1:0] ren_src_b,
    input  logic [SLOT_W-1:0] ren_slot,
    input  logic [TAG_W-1:0]  ren_btag,
    output logic [SLOT_W-1:0] src_a_slot,
    output logic              src_a_in_arf,
    output logic [SLOT_W-1:0] src_b_slot,
    output logic              src_b_in_arf,
    output logic              prev_valid,
    output logic [SLOT_W-1:0] prev_slot,
    input  logic              commit_valid,
    input  logic [AREG_W-1:0] commit_dst,
    input  logic [SLOT_W-1:0] commit_slot,
    input  logic              flush_to_arf,
    input  logic [SLOT_W-1:0] probe_slot,
    output logic              wb_short_lived,
    output logic [TAG_W-1:0]  probe_btag
);
    logic              dst_in_arf;
    logic [SLOT_W-1:0] dst_slot;
    logic              ren_act;
    logic              upd_en;
    logic              mark_en;
    logic              cmt_en;

    always_comb begin
        ren_act    = ren_valid && !flush_to_arf;
        upd_en     = ren_act && ren_has_dst;
        cmt_en     = commit_valid && !flush_to_arf;
        prev_valid = ren_valid && ren_has_dst && !dst_in_arf;
        prev_slot  = dst_slot;
        mark_en    = upd_en && !dst_in_arf;
    end

    lrt_map_table #(.NUM_AREGS(NUM_AREGS), .ROB_DEPTH(ROB_DEPTH)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_a      (ren_src_a),
        .src_b      (ren_src_b),
        .a_slot     (src_a_slot),
        .a_in_arf   (src_a_in_arf),
        .b_slot     (src_b_slot),
        .b_in_arf   (src_b_in_arf),
        .dst        (ren_dst),
        .dst_slot   (dst_slot),
        .dst_in_arf (dst_in_arf),
        .upd_en     (upd_en),
        .upd_slot   (ren_slot),
        .cmt_en     (cmt_en),
        .cmt_dst    (commit_dst),
        .cmt_slot   (commit_slot),
        .flush      (flush_to_arf)
    );

    lrt_renamed_vec #(.ROB_DEPTH(ROB_DEPTH)) u_renamed (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (mark_en),
        .set_idx (dst_slot),
        .clr_en  (ren_act),
        .clr_idx (ren_slot),
        .rd_idx  (probe_slot),
        .rd_bit  (wb_short_lived)
    );

    lrt_tag_array #(.ROB_DEPTH(ROB_DEPTH), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ren_act),
        .wr_idx (ren_slot),
        .wr_tag (ren_btag),
        .rd_idx (probe_slot),
        .rd_tag (probe_btag)
    );

    AST_NO_PREV_FROM_ARF: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_has_dst && src_a_in_arf && (ren_src_a == ren_dst))
        |-> !prev_valid); // R4

    AST_PREV_MATCHES_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && (ren_src_b == ren_dst)) |-> (prev_slot == src_b_slot)); // R5

endmodule

// File: tb/lifetime_rename_table_tb.sv
`timescale 1ns/1ps
module lifetime_rename_table_tb;
    localparam int NA = 8, RD = 16, TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       ren_valid = 0, ren_has_dst = 0, commit_valid = 0, flush_to_arf = 0;
    logic [2:0] ren_dst = 0, ren_src_a = 0, ren_src_b = 0, commit_dst = 0;
    logic [3:0] ren_slot = 0, ren_btag = 0, commit_slot = 0, probe_slot = 0;
    logic [3:0] src_a_slot, src_b_slot, prev_slot, probe_btag;
    logic       src_a_in_arf, src_b_in_arf, prev_valid, wb_short_lived;

    lifetime_rename_table #(.NUM_AREGS(NA), .ROB_DEPTH(RD), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_has_dst(ren_has_dst), .ren_dst(ren_dst),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_slot(ren_slot),
        .ren_btag(ren_btag),
        .src_a_slot(src_a_slot), .src_a_in_arf(src_a_in_arf),
        .src_b_slot(src_b_slot), .src_b_in_arf(src_b_in_arf),
        .prev_valid(prev_valid), .prev_slot(prev_slot),
        .commit_valid(commit_valid), .commit_dst(commit_dst),
        .commit_slot(commit_slot), .flush_to_arf(flush_to_arf),
        .probe_slot(probe_slot), .wb_short_lived(wb_short_lived),
        .probe_btag(probe_btag)
    );

    // Reference model state.
    bit       m_loc [NA];
    bit [3:0] m_idx [NA];
    bit       m_ren [RD];
    bit [3:0] m_tag [RD];

    typedef struct {
        string    req;
        bit       a_arf, b_arf, pv, sl;
        bit [3:0] a_slot, b_slot, p_slot, btag;
    } exp_t;
    exp_t sb[$];

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic step(input bit rv, input bit hd, input bit [2:0] dst,
                        input bit [2:0] sa, input bit [2:0] sbr,
                        input bit [3:0] slot, input bit [3:0] btag,
                        input bit cv, input bit [2:0] cdst, input bit [3:0] cslot,
                        input bit fl, input bit [3:0] probe, input string req);
        exp_t e;
        bit prior;
        @(negedge clk);
        ren_valid = rv; ren_has_dst = hd; ren_dst = dst; ren_src_a = sa;
        ren_src_b = sbr; ren_slot = slot; ren_btag = btag;
        commit_valid = cv; commit_dst = cdst; commit_slot = cslot;
        flush_to_arf = fl; probe_slot = probe;
        prior    = hd && !m_loc[dst];
        e.req    = req;
        e.a_arf  = m_loc[sa];  e.a_slot = m_idx[sa];
        e.b_arf  = m_loc[sbr]; e.b_slot = m_idx[sbr];
        e.pv     = rv && prior; e.p_slot = m_idx[dst];
        e.sl     = m_ren[probe]; e.btag = m_tag[probe];
        sb.push_back(e);
        // Apply this cycle's effects for the following cycles.
        if (fl) begin
            for (int i = 0; i < NA; i++) begin m_loc[i] = 1; m_idx[i] = 0; end
        end else begin
            if (cv && !m_loc[cdst] && m_idx[cdst] == cslot && !(rv && hd && dst == cdst))
                m_loc[cdst] = 1;
            if (rv) begin
                if (prior) m_ren[m_idx[dst]] = 1;
                m_ren[slot] = 0;
                m_tag[slot] = btag;
                if (hd) begin m_loc[dst] = 0; m_idx[dst] = slot; end
            end
        end
    endtask

    task automatic idle(input bit [2:0] sa, input bit [2:0] sbr,
                        input bit [3:0] probe, input string req);
        step(0, 0, 0, sa, sbr, 0, 0, 0, 0, 0, 0, probe, req);
    endtask

    // Monitor: compares the combinational outputs mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t e;
                bit bad;
                e = sb.pop_front();
                bad = (src_a_in_arf !== e.a_arf) || (!e.a_arf && src_a_slot !== e.a_slot)
                   || (src_b_in_arf !== e.b_arf) || (!e.b_arf && src_b_slot !== e.b_slot)
                   || (prev_valid !== e.pv) || (e.pv && prev_slot !== e.p_slot)
                   || (wb_short_lived !== e.sl) || (probe_btag !== e.btag);
                n_cmp++;
                if (bad) begin
                    n_bad++;
                    $display("FAIL %s: act a=%b/%0d b=%b/%0d pv=%b/%0d sl=%b tag=%0d exp a=%b/%0d b=%b/%0d pv=%b/%0d sl=%b tag=%0d",
                        e.req, src_a_in_arf, src_a_slot, src_b_in_arf, src_b_slot,
                        prev_valid, prev_slot, wb_short_lived, probe_btag,
                        e.a_arf, e.a_slot, e.b_arf, e.b_slot, e.pv, e.p_slot, e.sl, e.btag);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: act hung exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit [15:0] lf;
        for (int i = 0; i < NA; i++) begin m_loc[i] = 1; m_idx[i] = 0; end
        for (int i = 0; i < RD; i++) begin m_ren[i] = 0; m_tag[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: reset state
        idle(0, 7, 0, "R1 reset map/flags");
        idle(3, 5, 15, "R1 reset probe");
        // R4: destination held in register file, no prior producer
        step(1, 1, 1, 1, 2, 3, 2, 0, 0, 0, 0, 3, "R4 dst from ARF");
        // R2: new mapping visible; R5 pre-update reads
        step(1, 1, 5, 1, 5, 4, 2, 0, 0, 0, 0, 3, "R2 mapping to slot");
        step(1, 1, 1, 5, 1, 5, 7, 0, 0, 0, 0, 3, "R3/R5 prior producer");
        // R8: probe flagged slot and an unflagged one
        idle(1, 5, 3, "R8 probe flagged slot3");
        idle(1, 5, 4, "R8 probe slot4");
        idle(1, 5, 5, "R6 tag of slot5");
        // R9: stale commit ignored, matching commit retires
        step(0, 0, 0, 1, 1, 0, 0, 1, 1, 3, 0, 3, "R9 stale commit");
        step(0, 0, 0, 1, 5, 0, 0, 1, 5, 4, 0, 3, "R9 matching commit");
        idle(1, 5, 3, "R9 after commit");
        // R7: reallocation without destination clears flag
        step(1, 0, 0, 1, 5, 3, 9, 0, 0, 0, 0, 3, "R7 realloc no dst");
        idle(1, 5, 3, "R7 flag cleared, R6 new tag");
        // R9: rename beats commit on same destination
        step(1, 1, 1, 1, 1, 6, 4, 1, 1, 5, 0, 5, "R9 rename vs commit");
        idle(1, 5, 5, "R9 precedence result");
        // R10: flush overrides rename and commit
        step(1, 1, 1, 1, 1, 8, 11, 1, 1, 6, 1, 8, "R10 flush with rename");
        idle(1, 5, 8, "R10 all ARF, tag8 untouched");
        idle(1, 5, 5, "R10 flags untouched");
        // R7: collision, reallocated slot equals prior producer slot
        step(1, 1, 2, 2, 2, 9, 1, 0, 0, 0, 0, 9, "R7 setup slot9");
        step(1, 1, 2, 2, 2, 9, 2, 0, 0, 0, 0, 9, "R7 collision");
        idle(2, 2, 9, "R7 clear wins");
        // Mixed traffic against the model
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[1], lf[2] | lf[3], lf[6:4], lf[9:7], lf[12:10],
                 lf[15:12], lf[3:0], lf[5] & lf[8], lf[8:6], lf[13:10],
                 (lf[15:11] == 5'd3), lf[11:8], "R3/R9 mixed traffic");
        end
        idle(0, 1, 0, "R8 final");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule